// File: doc/BRIEF.md
# Fractional Clock-Enable Divider Bank

This block holds a bank of independent divider channels. Each channel turns a fixed-point divisor, with a 16-bit whole part and an 8-bit part counted in 1/256ths, into a stream of single-cycle enable pulses. A downstream sequencer advances only on cycles where its enable is high, so it runs at the system clock rate divided by the programmed divisor. Whole-number divisors give perfectly regular spacing. Fractional divisors give the exact average rate, and the spacing between pulses alternates between the two nearest whole cycle counts.

Every channel keeps a phase accumulator that is advanced by one unit each system cycle. The channel emits a pulse and subtracts its divisor whenever the accumulator reaches the divisor. The channels run freely and have no enable. A restart mask clears the phase of any set of channels in one cycle. Channels restarted together with equal divisors then emit identical pulse trains. A divisor written without a restart is taken up at the next pulse, and the phase carries over unchanged.

Top module: `fracdiv_bank`

## Requirements
- R1: While reset is asserted every enable output is low. After reset each channel runs with a divisor of 1.0 until its first pulse, so every enable is high in the first cycle after reset is released.
- R2: With a whole divisor n (fraction 0), a channel pulses exactly once every n cycles. The first pulse comes n cycles after a restart.
- R3: A divisor of 1.0 produces an enable in every cycle.
- R4: With divisor D = whole + fraction/256, the k-th cycle after a restart carries a pulse exactly when floor(k/D) exceeds floor((k-1)/D). Pulse gaps are therefore floor(D) or ceil(D) cycles.
- R5: A restart clears the phase of the channel. Its enable is low in the cycle after the restart, and the pulse pattern starts over from phase zero.
- R6: Channels restarted in the same cycle with equal divisors produce identical enable outputs from then on, for as long as their divisors stay equal.
- R7: A restart affects only the channels whose mask bit is 1. Other channels keep their pattern unchanged.
- R8: A whole-part field of 0 stands for 65536. With fraction 0 a channel then pulses once every 65536 cycles.
- R9: A divisor changed without a restart is sampled at the channel's next pulse. The spacing after that pulse follows the new value, and the phase is not reset.
- R10: A restart may be issued at any phase while the channel is running, and it takes effect in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_int | input | NUM_CH*INT_W | Whole part of each channel's divisor, channel c at bits [c*INT_W +: INT_W] |
| div_frac | input | NUM_CH*FRAC_W | Fractional part of each divisor in 1/256ths, channel c at bits [c*FRAC_W +: FRAC_W] |
| restart | input | NUM_CH | Per-channel phase restart, bit c for channel c |
| tick | output | NUM_CH | One-cycle enable per channel, bit c for channel c |

## Verification
The lockstep and unity-rate assertions assume that the divisor inputs are not glitched between edges, so that the values present at an edge are the values a channel latches. The stimulus therefore changes inputs only at the falling edge. The reference model in the bench assumes that a divisor changes without a restart only when the channel's phase is exactly zero at its next pulse. To keep within that, random divisor changes always come with a restart, and the single mid-run change is made on a whole-number divisor.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
    localparam int DEF_NUM_CH = 4;
    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 8;
endpackage

// File: rtl/fracdiv_decode.sv
module fracdiv_decode #(
    parameter int INT_W  = fracdiv_pkg::DEF_INT_W,
    parameter int FRAC_W = fracdiv_pkg::DEF_FRAC_W,
    localparam int DIV_W = INT_W + FRAC_W + 1
) (
    input  logic [INT_W-1:0]  whole_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [DIV_W-1:0]  div_o
);
    logic whole_zero;

    // a zero whole part expands to 2**INT_W by setting the extra top bit
    always_comb begin
        whole_zero = (whole_i == '0);
        div_o      = {whole_zero, whole_i, frac_i};
    end
endmodule

// File: rtl/fracdiv_channel.sv
module fracdiv_channel #(
    parameter int INT_W  = fracdiv_pkg::DEF_INT_W,
    parameter int FRAC_W = fracdiv_pkg::DEF_FRAC_W,
    localparam int DIV_W = INT_W + FRAC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_in,
    input  logic             restart_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] STEP = DIV_W'(1) << FRAC_W;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
        logic [DIV_W-1:0] div_act;
        logic             tick;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [DIV_W-1:0] phase_sum;

    always_comb begin
        st_d      = st_q;
        phase_sum = st_q.phase + STEP;
        if (restart_i) begin
            st_d.phase   = '0;
            st_d.div_act = div_in;
            st_d.tick    = 1'b0;
        end else if (phase_sum >= st_q.div_act) begin
            st_d.phase   = phase_sum - st_q.div_act;
            st_d.div_act = div_in;
            st_d.tick    = 1'b1;
        end else begin
            st_d.phase = phase_sum;
            st_d.tick  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= '0;
            st_q.div_act <= STEP;
            st_q.tick    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/fracdiv_bank.sv
module fracdiv_bank #(
    parameter int NUM_CH = fracdiv_pkg::DEF_NUM_CH,
    parameter int INT_W  = fracdiv_pkg::DEF_INT_W,
    parameter int FRAC_W = fracdiv_pkg::DEF_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH*INT_W-1:0]  div_int,
    input  logic [NUM_CH*FRAC_W-1:0] div_frac,
    input  logic [NUM_CH-1:0]        restart,
    output logic [NUM_CH-1:0]        tick
);
    localparam int DIV_W = INT_W + FRAC_W + 1;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DIV_W-1:0] div_eff;

        fracdiv_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_dec (
            .whole_i (div_int[c*INT_W +: INT_W]),
            .frac_i  (div_frac[c*FRAC_W +: FRAC_W]),
            .div_o   (div_eff)
        );

        fracdiv_channel #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .div_in    (div_eff),
            .restart_i (restart[c]),
            .tick_o    (tick[c])
        );
    end
endmodule

// File: rtl/fracdiv_bank_chk.sv
module fracdiv_bank_chk #(
    parameter int NUM_CH = fracdiv_pkg::DEF_NUM_CH,
    parameter int INT_W  = fracdiv_pkg::DEF_INT_W,
    parameter int FRAC_W = fracdiv_pkg::DEF_FRAC_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH*INT_W-1:0]  div_int,
    input logic [NUM_CH*FRAC_W-1:0] div_frac,
    input logic [NUM_CH-1:0]        restart,
    input logic [NUM_CH-1:0]        tick
);
    localparam int GAP_W   = INT_W + 2;
    localparam int MAX_GAP = (1 << INT_W) + 1;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_one
        logic [GAP_W-1:0] gap_q;
        logic             unity_q;
        logic             unity_now;

        assign unity_now = (div_int[i*INT_W +: INT_W] == INT_W'(1)) &&
                           (div_frac[i*FRAC_W +: FRAC_W] == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gap_q   <= '0;
                unity_q <= 1'b0;
            end else begin
                unity_q <= unity_now;
                if (tick[i] || restart[i]) gap_q <= '0;
                else                       gap_q <= gap_q + 1'b1;
            end
        end

        AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            restart[i] |=> !tick[i]); // R5

        AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            gap_q < GAP_W'(MAX_GAP)); // R8

        AST_UNITY_RATE: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[i] && unity_q && !restart[i]) |=> tick[i]); // R3
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pa
        for (genvar j = i + 1; j < NUM_CH; j++) begin : g_pb
            logic same_q;
            logic div_eq;

            assign div_eq = (div_int[i*INT_W +: INT_W] == div_int[j*INT_W +: INT_W]) &&
                            (div_frac[i*FRAC_W +: FRAC_W] == div_frac[j*FRAC_W +: FRAC_W]);

            always_ff @(posedge clk) begin
                if (!rst_n)                                  same_q <= 1'b0;
                else if (restart[i] && restart[j] && div_eq) same_q <= 1'b1;
                else if ((restart[i] != restart[j]) || !div_eq) same_q <= 1'b0;
            end

            AST_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
                same_q |-> (tick[i] == tick[j])); // R6
        end
    end
endmodule

bind fracdiv_bank fracdiv_bank_chk #(
    .NUM_CH(NUM_CH), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
    .restart(restart), .tick(tick)
);

// File: tb/fracdiv_bank_test.sv
module fracdiv_bank_test;
    localparam int NCH = 4;
    localparam int IW  = 16;
    localparam int FW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH*IW-1:0] div_int;
    logic [NCH*FW-1:0] div_frac;
    logic [NCH-1:0]    restart;
    logic [NCH-1:0]    tick;

    int  din_i [NCH];
    int  din_f [NCH];
    bit  rs    [NCH];
    longint k_m [NCH];
    longint d_m [NCH];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            div_int[c*IW +: IW]  = IW'(din_i[c]);
            div_frac[c*FW +: FW] = FW'(din_f[c]);
            restart[c]           = rs[c];
        end
    end

    fracdiv_bank uut (
        .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac),
        .restart(restart), .tick(tick)
    );

    function automatic longint eff_div(int w, int f);
        return (w == 0 ? 64'd65536 : longint'(w)) * 256 + longint'(f);
    endfunction

    // pulse at cycle k when floor(k/D) steps up (D in 1/256 units)
    function automatic bit pulse_at(longint k, longint d);
        return ((k * 256) / d) != (((k - 1) * 256) / d);
    endfunction

    task automatic check(bit ok, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    task automatic run_cycle();
        longint di [NCH];
        bit     rr [NCH];
        bit     e;
        for (int c = 0; c < NCH; c++) begin
            di[c] = eff_div(din_i[c], din_f[c]);
            rr[c] = rs[c];
        end
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (rr[c]) begin
                k_m[c] = 0;
                d_m[c] = di[c];
                e = 1'b0;
            end else begin
                k_m[c] = k_m[c] + 1;
                e = pulse_at(k_m[c], d_m[c]);
                if (e && ((k_m[c] * 256) % d_m[c]) == 0) begin
                    k_m[c] = 0;
                    d_m[c] = di[c];
                end
            end
            check(tick[c] == e, $sformatf("tick ch%0d", c), int'(tick[c]), int'(e));
            rs[c] = 1'b0;
        end
    endtask

    task automatic set_ch(int c, int w, int f, bit r);
        din_i[c] = w;
        din_f[c] = f;
        rs[c]    = r;
    endtask

    initial begin
        #(20ns * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < NCH; c++) begin
            set_ch(c, 3 + c, 0, 1'b0);
            k_m[c] = 0;
            d_m[c] = 256;
        end
        // R1: outputs low during reset
        repeat (3) @(negedge clk);
        cur_req = "R1";
        for (int c = 0; c < NCH; c++)
            check(tick[c] == 1'b0, $sformatf("reset tick ch%0d", c), int'(tick[c]), 0);
        rst_n = 1'b1;
        // R1: first cycle ticks at 1.0, then the programmed divisor is taken
        repeat (12) run_cycle();

        // R2 R3: whole divisors 1, 2, 3, 7
        cur_req = "R2 R3";
        set_ch(0, 1, 0, 1'b1);
        set_ch(1, 2, 0, 1'b1);
        set_ch(2, 3, 0, 1'b1);
        set_ch(3, 7, 0, 1'b1);
        repeat (50) run_cycle();

        // R4: fractional divisors 2.5, 1.5, 3+25/256, 1+255/256
        cur_req = "R4";
        set_ch(0, 2, 128, 1'b1);
        set_ch(1, 1, 128, 1'b1);
        set_ch(2, 3, 25, 1'b1);
        set_ch(3, 1, 255, 1'b1);
        repeat (300) run_cycle();

        // R9: whole divisor changed mid-run without restart
        cur_req = "R9";
        set_ch(0, 4, 0, 1'b1);
        repeat (6) run_cycle();
        set_ch(0, 2, 0, 1'b0);
        repeat (20) run_cycle();

        // R5 R10: restart a fractional channel at an arbitrary phase
        cur_req = "R5 R10";
        repeat (5) run_cycle();
        set_ch(1, 1, 128, 1'b1);
        repeat (30) run_cycle();

        // R6 R7: joint restart of ch1 and ch2, ch3 untouched
        cur_req = "R6 R7";
        set_ch(1, 1, 192, 1'b1);
        set_ch(2, 1, 192, 1'b1);
        for (int n = 0; n < 100; n++) begin
            run_cycle();
            check(tick[1] == tick[2], "lockstep ch1 vs ch2", int'(tick[1]), int'(tick[2]));
        end

        // R8: whole part 0 means 65536
        cur_req = "R8 R7";
        set_ch(0, 0, 0, 1'b1);
        repeat (65540) run_cycle();

        // random mix of restarts and divisors
        cur_req = "R4 R5 R6 R10 random";
        for (int n = 0; n < 5000; n++) begin
            for (int c = 0; c < NCH; c++) begin
                if ($urandom % 40 == 0)
                    set_ch(c, 1 + int'($urandom % 6), ($urandom % 2) ? int'($urandom % 256) : 0, 1'b1);
            end
            if ($urandom % 150 == 0) begin
                int w = 1 + int'($urandom % 4);
                int f = int'($urandom % 256);
                set_ch(1, w, f, 1'b1);
                set_ch(2, w, f, 1'b1);
            end
            run_cycle();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule